// File: doc/BRIEF.md
# Secondary Bus Mode Detector

This block acts as the central resource of a secondary PCI/PCI-X bus. After reset, it works out which operating mode every client on that bus can support. It watches a capability net that the clients load. The net has a weak external pull-up, and the block can switch a strong pull-up onto it through an enable output. The block can also read a frequency-range select strap. Both inputs are asynchronous, so each passes through a synchronizer chain before any decision uses it.

Detection starts when reset is released or when a start pulse arrives. The block first samples the capability net with the strong pull-up switched off:

- A high reading means every client is high-speed capable. The select strap then chooses between the 100 MHz and 133 MHz ranges.
- A low reading is ambiguous. The net is either tied to ground or only pulled down through a resistor. To tell these apart, the block switches the strong pull-up on, waits a programmable number of cycles, and samples again. A net that stays low means conventional PCI. A net that rises means PCI-X 66.

When the decision is made, the block does three things. It switches the pull-up off, raises a done flag, and holds a 2-bit mode code. A parameter table maps that code to a 3-bit initialization pattern, which a separate bus driver presents.

Top module: `bus_mode_detect`

## Requirements
- R1: While reset is asserted, and in the cycle after a start pulse, `pullup_en` and `done` are both 0. A start pulse is accepted in any state and restarts detection. Detection also starts by itself when reset is released.
- R2: `cap_in` and `fsel_in` each pass through a `SYNC_STAGES`-flop synchronizer. When a start pulse is sampled at clock edge 0, the first capability sample is taken with `pullup_en` at 0 and decides at edge `SYNC_STAGES`+1.
- R3: If the first sample is 1, `pullup_en` is never asserted. `done` rises `SYNC_STAGES`+1 cycles after the start edge. `mode` is 2'b10 (PCI-X 100) when the synchronized select is 1, and 2'b11 (PCI-X 133) when it is 0.
- R4: If the first sample is 0, `pullup_en` is 1 for exactly `SETTLE_CYCLES` consecutive cycles and is 0 again when `done` rises. `done` rises `SYNC_STAGES`+1+`SETTLE_CYCLES` cycles after the start edge.
- R5: If the capability net still reads 0 at the end of the settling window, `mode` is 2'b00 (conventional PCI).
- R6: If the capability net reads 1 at the end of the settling window, `mode` is 2'b01 (PCI-X 66).
- R7: Once `done` is 1, `done` and `mode` hold, and `pullup_en` stays 0, until the next start pulse. Changes on `cap_in` and `fsel_in` in that period have no effect.
- R8: `init_pattern` equals bits [3*m+2:3*m] of the parameter `PATTERN_MAP`, where m is the current `mode` code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that restarts detection |
| cap_in | input | 1 | Asynchronous capability net level |
| fsel_in | input | 1 | Asynchronous frequency-range select strap |
| pullup_en | output | 1 | Switches the strong pull-up onto the capability net |
| done | output | 1 | Decision made; mode is valid |
| mode | output | 2 | 00 conventional, 01 PCI-X 66, 10 PCI-X 100, 11 PCI-X 133 |
| init_pattern | output | 3 | Initialization pattern looked up from `PATTERN_MAP` |

## Verification
The bench models the net in three ways. A tied net reads low whatever the pull-up does. A resistively pulled-down net reads high only while `pullup_en` is on. A free net reads high throughout. Tied against pulled-down separates conventional PCI from PCI-X 66, which only the second sample can tell apart. The free net, combined with both strap levels, separates the 100 and 133 ranges and shows the pull-up is never used on that path. Restarts in the middle of the settling window, and input changes after `done`, check that a new start gives a clean run and that a finished decision is frozen.

// File: rtl/bus_mode_detect.sv
module bus_mode_detect #(
  parameter int          SETTLE_CYCLES = 1024,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [11:0] PATTERN_MAP   = 12'b111_110_101_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cap_in,
  input  logic       fsel_in,
  output logic       pullup_en,
  output logic       done,
  output logic [1:0] mode,
  output logic [2:0] init_pattern
);

  localparam int CW = $clog2(SETTLE_CYCLES + SYNC_STAGES + 1);
  localparam logic [CW-1:0] FLUSH_LAST  = CW'(SYNC_STAGES - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  localparam logic [1:0] M_CONV = 2'b00;
  localparam logic [1:0] M_X66  = 2'b01;
  localparam logic [1:0] M_X100 = 2'b10;
  localparam logic [1:0] M_X133 = 2'b11;

  typedef enum logic [1:0] {S_FLUSH, S_PROBE, S_SETTLE, S_HOLD} state_t;

  state_t                 state;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] cap_sr, fsel_sr;
  logic                   cap_s, fsel_s;

  assign cap_s  = cap_sr[SYNC_STAGES-1];
  assign fsel_s = fsel_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sr  <= '0;
      fsel_sr <= '0;
    end else begin
      cap_sr  <= {cap_sr[SYNC_STAGES-2:0], cap_in};
      fsel_sr <= {fsel_sr[SYNC_STAGES-2:0], fsel_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FLUSH;
      cnt       <= '0;
      pullup_en <= 1'b0;
      done      <= 1'b0;
      mode      <= M_CONV;
    end else if (start) begin
      state     <= S_FLUSH;
      cnt       <= '0;
      pullup_en <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (state)
        S_FLUSH: begin
          if (cnt == FLUSH_LAST) begin
            cnt   <= '0;
            state <= S_PROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROBE: begin
          if (cap_s) begin
            mode  <= fsel_s ? M_X100 : M_X133;
            done  <= 1'b1;
            state <= S_HOLD;
          end else begin
            pullup_en <= 1'b1;
            cnt       <= '0;
            state     <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            mode      <= cap_s ? M_X66 : M_CONV;
            pullup_en <= 1'b0;
            done      <= 1'b1;
            state     <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_CONV:  init_pattern = PATTERN_MAP[2:0];
      M_X66:   init_pattern = PATTERN_MAP[5:3];
      M_X100:  init_pattern = PATTERN_MAP[8:6];
      default: init_pattern = PATTERN_MAP[11:9];
    endcase
  end

endmodule

module bus_mode_detect_props (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       pullup_en,
  input logic       done,
  input logic [1:0] mode
);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!pullup_en && !done));

  assert_fast_path_no_pullup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(pullup_en)) |-> mode[1]);

  assert_slow_path_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(pullup_en)) |-> !mode[1]);

  assert_pullup_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en && !start) |=> (pullup_en || done));

  assert_pullup_off_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pullup_en);

  assert_hold_until_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(mode)));

endmodule

bind bus_mode_detect bus_mode_detect_props i_props (
  .clk(clk), .rst_n(rst_n), .start(start),
  .pullup_en(pullup_en), .done(done), .mode(mode)
);

// File: tb/test_bus_mode_detect.sv
module test_bus_mode_detect;
  localparam int          CLK_PERIOD = 10;
  localparam int          SETTLE     = 40;
  localparam int          SYNC       = 2;
  localparam logic [11:0] MAP        = 12'b011_110_001_101;
  localparam int          LIMIT      = 150000;

  localparam logic [1:0] NET_TIED = 2'd0;
  localparam logic [1:0] NET_PULLDOWN = 2'd1;
  localparam logic [1:0] NET_FREE = 2'd2;

  logic clk = 0, rst_n = 0, start = 0, fsel_in = 0;
  logic [1:0] net_kind = NET_FREE;
  logic cap_in, pullup_en, done;
  logic [1:0] mode;
  logic [2:0] init_pattern;
  int checks = 0, errors = 0, cycles = 0;

  assign cap_in = (net_kind == NET_FREE) || (net_kind == NET_PULLDOWN && pullup_en);

  bus_mode_detect #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC), .PATTERN_MAP(MAP)) i_bus_mode_detect (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_in(cap_in), .fsel_in(fsel_in),
    .pullup_en(pullup_en), .done(done), .mode(mode), .init_pattern(init_pattern)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired: actual=%0d expected<=%0d cycles", cycles, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [1:0] exp_mode(input logic [1:0] kind, input logic sel);
    if (kind == NET_FREE) return sel ? 2'b10 : 2'b11;
    if (kind == NET_PULLDOWN) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [2:0] exp_pattern(input logic [1:0] m);
    case (m)
      2'b00: return 3'b101;
      2'b01: return 3'b001;
      2'b10: return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(input logic [1:0] kind, input logic sel, input bit restart);
    int n = 0, pu = 0, lat;
    logic [1:0] em;
    net_kind = kind; fsel_in = sel;
    repeat (4) @(negedge clk);
    if (restart) begin
      pulse_start();
      repeat (SYNC + 4) @(negedge clk);
    end
    pulse_start();
    check("R1", "pullup after start", int'(pullup_en), 0);
    check("R1", "done after start", int'(done), 0);
    while (!done && n < 4 * SETTLE) begin
      if (pullup_en) pu++;
      @(negedge clk); n++;
    end
    em = exp_mode(kind, sel);
    lat = (kind == NET_FREE) ? SYNC + 1 : SYNC + 1 + SETTLE;
    if (kind == NET_FREE) begin
      check("R3", "pullup cycles on fast path", pu, 0);
      check("R2", "fast path latency", n, lat);
    end else begin
      check("R4", "pullup cycles in settle window", pu, SETTLE);
      check("R4", "slow path latency", n, lat);
    end
    check(kind == NET_TIED ? "R5" : kind == NET_PULLDOWN ? "R6" : "R3", "mode", int'(mode), int'(em));
    check("R4", "pullup off at done", int'(pullup_en), 0);
    check("R8", "init_pattern", int'(init_pattern), int'(exp_pattern(mode)));
    net_kind = NET_TIED + 2'($urandom % 3); fsel_in = ~fsel_in;
    repeat (SYNC + 6) @(negedge clk);
    check("R7", "mode held", int'(mode), int'(em));
    check("R7", "done held", int'(done), 1);
    check("R7", "pullup stays off", int'(pullup_en), 0);
  endtask

  initial begin
    void'($urandom(32'd1337));
    net_kind = NET_FREE; fsel_in = 1;
    repeat (3) @(negedge clk);
    check("R1", "reset pullup", int'(pullup_en), 0);
    check("R1", "reset done", int'(done), 0);
    rst_n = 1;
    repeat (SYNC + 4) @(negedge clk);
    check("R1", "done after reset release", int'(done), 1);
    check("R3", "mode after reset release", int'(mode), 2);

    run(NET_TIED, 0, 0);
    run(NET_PULLDOWN, 1, 0);
    run(NET_FREE, 1, 0);
    run(NET_FREE, 0, 0);
    run(NET_PULLDOWN, 0, 1);
    run(NET_TIED, 1, 1);
    for (int i = 0; i < 40; i++)
      run(2'($urandom % 3), 1'($urandom % 2), 1'($urandom % 4 == 0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule